// File: doc/BRIEF.md
# PTE Accessed/Dirty Update Unit

This stage sits inside a page-table walker, after the walk has reached a leaf entry. The walker hands it the physical address of the leaf, the kind of access that started translation (instruction fetch, load or store), whether that access was explicit or implicit, and whether the entry belongs to first-stage or guest-stage translation. The unit reads the entry and checks its accessed flag. On a store it also checks its dirty flag. When a flag that must be one is zero, the unit does one of two things. It reports a page fault, or it sets the flags itself with an atomic compare-and-swap on the entry. A run-time selection bit picks the action.

There are two selection bits. The machine-level bit governs first-stage translation. A separate hypervisor-level bit governs guest-stage translation, and it only takes effect when the machine-level bit is also set. Both bits sit in a small WARL register inside the unit. A build parameter decides whether that register is writable or reads as zero. It can never read as one.

Protection and attribute results for the entry's location come in on three check inputs. These are a read permission, a write permission and a cacheable-main-memory flag. They are held stable by the walker for the whole request. The memory system is modelled as a single request/response port with a read operation and a compare-and-swap operation. Every request ends in one of three outcomes, reported with a one-cycle pulse: done, page fault or access fault.

Top module: `pte_ad_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `cfg_rdata` is 0.
- R2: If the entry read has its accessed flag (bit 6) set, and is either not for a store or has its dirty flag (bit 7) set, the outcome is done (code 0). No write is issued and `rsp_pte` returns the value read.
- R3: Access type encoding is 0 fetch, 1 load, 2 store (3 behaves as a load). When an update is needed and the governing selection bit is 0, the outcome is page fault (code 1) and the entry is not written. `rsp_guest` echoes `req_guest`, so a guest-stage request yields a guest page fault.
- R4: When an update is needed and hardware update is selected, a fetch or load sets only bit 6. A store sets bits 6 and 7 together in one compare-and-swap. The outcome is done and `rsp_pte` returns the new value.
- R5: Guest-stage requests (`req_guest`=1) use hardware update only when both `cfg_wdata` bit 0 (machine select) and bit 1 (guest select) were written as 1. Otherwise they take the page-fault path. First-stage requests use bit 0 alone.
- R6: The selection register is written by `cfg_we` and read on `cfg_rdata`. With `HW_AD_EN`=1 both bits hold the written values. With `HW_AD_EN`=0 they always read 0, and no bit can ever read 1 without having been written 1.
- R7: If `chk_rd_ok` is 0, the outcome is access fault (code 2), no memory read is issued, and `rsp_acc` equals the request's access type.
- R8: If an update is needed and selected, but `chk_wr_ok` is 0 or `chk_cacheable` is 0, the outcome is access fault (code 2) with the original access type. No write is issued.
- R9: A compare-and-swap compares against the value read. If the memory reports a mismatch, the unit re-reads the entry and evaluates it again, and never overwrites the changed value.
- R10: The explicit/implicit input does not change the outcome, the memory traffic or the resulting entry. It is echoed on `rsp_implicit`.
- R11: Every write only sets bits relative to its compare value. A flag set by an update remains set, and later requests on that entry complete as done without writing.
- R12: `rsp_valid` is a single-cycle pulse with `rsp_code` in {0,1,2}. `req_ready` is 1 only while the unit is idle and returns to 1 the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the selection register |
| cfg_wdata | input | 2 | Bit 0 machine/first-stage select, bit 1 guest select |
| cfg_rdata | output | 2 | Selection register read value |
| req_valid | input | 1 | Leaf request strobe, taken when ready |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | AW | Physical address of the leaf entry |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_implicit | input | 1 | Triggering access was implicit |
| req_guest | input | 1 | Entry belongs to guest-stage translation |
| chk_rd_ok | input | 1 | Reading the entry location is permitted |
| chk_wr_ok | input | 1 | Writing the entry location is permitted |
| chk_cacheable | input | 1 | Entry location is cacheable main memory |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | 0 read, 1 compare-and-swap |
| mem_req_addr | output | AW | Memory request address |
| mem_req_cmp | output | PW | Compare value for compare-and-swap |
| mem_req_wdata | output | PW | Swap value for compare-and-swap |
| mem_rsp_valid | input | 1 | Memory response pulse |
| mem_rsp_ok | input | 1 | Compare-and-swap matched and wrote |
| mem_rsp_rdata | input | PW | Read data |
| rsp_valid | output | 1 | Outcome pulse |
| rsp_code | output | 2 | 0 done, 1 page fault, 2 access fault |
| rsp_guest | output | 1 | Echo of the request's stage |
| rsp_acc | output | 2 | Echo of the request's access type |
| rsp_implicit | output | 1 | Echo of the explicit/implicit flag |
| rsp_pte | output | PW | Final entry value on done |

## Verification
The bench targets the compare-and-swap race. A second agent sets a flag between the read and the swap. A design that skips the re-read would either clobber that flag or report done with a stale entry. It drives stores whose entry already has the accessed flag but lacks dirty. A design that writes only the accessed flag would leave dirty clear, and one that takes the shortcut on any set flag would report done with nothing written. It checks the guest path with only one of the two selection bits set, where a single-bit decode would update instead of faulting. It also blocks the write or marks the location non-cacheable, where a design that checks only the read permission would still issue the swap. The unsupported-register build is checked to read zero after writes of ones.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        OUT_DONE   = 2'd0,
        OUT_PAGE   = 2'd1,
        OUT_ACCESS = 2'd2
    } outcome_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CHK,
        S_RD_REQ,
        S_RD_WAIT,
        S_EVAL,
        S_WR_CHK,
        S_CAS_REQ,
        S_CAS_WAIT,
        S_RESP
    } state_e;

endpackage

// File: rtl/pte_ad_cfg.sv
module pte_ad_cfg #(
    parameter bit HW_AD_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic       sel_m,
    output logic       sel_h
);

    generate
        if (HW_AD_EN) begin : g_writable
            logic [1:0] sel_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_q <= 2'b00;
                end else if (cfg_we) begin
                    sel_q <= cfg_wdata;
                end
            end
            assign sel_m = sel_q[0];
            assign sel_h = sel_q[1];
        end else begin : g_zero
            // Read-only-zero variant: writes are discarded.
            assign sel_m = 1'b0;
            assign sel_h = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pte_ad_eval.sv
module pte_ad_eval #(
    parameter int PW    = 32,
    parameter int A_BIT = 6,
    parameter int D_BIT = 7
) (
    input  logic [PW-1:0] pte,
    input  logic [1:0]    acc,
    input  logic          guest,
    input  logic          sel_m,
    input  logic          sel_h,
    output logic          need_upd,
    output logic          hw_ok,
    output logic [PW-1:0] new_pte
);
    import pte_ad_pkg::*;

    localparam logic [PW-1:0] A_MASK = PW'(1) << A_BIT;
    localparam logic [PW-1:0] D_MASK = PW'(1) << D_BIT;

    logic is_store;

    always_comb begin
        is_store = (acc == ACC_STORE);
        need_upd = !pte[A_BIT] || (is_store && !pte[D_BIT]);
        // Guest stage needs both levels enabled; first stage only the machine bit.
        hw_ok    = guest ? (sel_m && sel_h) : sel_m;
        new_pte  = pte | A_MASK | (is_store ? D_MASK : '0);
    end

endmodule

// File: rtl/pte_ad_unit.sv
module pte_ad_unit #(
    parameter int AW       = 32,
    parameter int PW       = 32,
    parameter int A_BIT    = 6,
    parameter int D_BIT    = 7,
    parameter bit HW_AD_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_wdata,
    output logic [1:0]    cfg_rdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_acc,
    input  logic          req_implicit,
    input  logic          req_guest,
    input  logic          chk_rd_ok,
    input  logic          chk_wr_ok,
    input  logic          chk_cacheable,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [PW-1:0] mem_req_cmp,
    output logic [PW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_ok,
    input  logic [PW-1:0] mem_rsp_rdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic          rsp_guest,
    output logic [1:0]    rsp_acc,
    output logic          rsp_implicit,
    output logic [PW-1:0] rsp_pte
);
    import pte_ad_pkg::*;

    state_e        st_q, st_d;
    outcome_e      out_q, out_d;
    logic [AW-1:0] addr_q;
    logic [1:0]    acc_q;
    logic          guest_q;
    logic          impl_q;
    logic [PW-1:0] pte_q;

    logic          sel_m, sel_h;
    logic          need_upd, hw_ok;
    logic [PW-1:0] new_pte;

    pte_ad_cfg #(
        .HW_AD_EN (HW_AD_EN)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sel_m     (sel_m),
        .sel_h     (sel_h)
    );

    pte_ad_eval #(
        .PW    (PW),
        .A_BIT (A_BIT),
        .D_BIT (D_BIT)
    ) u_eval (
        .pte      (pte_q),
        .acc      (acc_q),
        .guest    (guest_q),
        .sel_m    (sel_m),
        .sel_h    (sel_h),
        .need_upd (need_upd),
        .hw_ok    (hw_ok),
        .new_pte  (new_pte)
    );

    // State register and the data captured along the way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            out_q   <= OUT_DONE;
            addr_q  <= '0;
            acc_q   <= '0;
            guest_q <= 1'b0;
            impl_q  <= 1'b0;
            pte_q   <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
            if (st_q == S_IDLE && req_valid) begin
                addr_q  <= req_addr;
                acc_q   <= req_acc;
                guest_q <= req_guest;
                impl_q  <= req_implicit;
            end
            if (st_q == S_RD_WAIT && mem_rsp_valid) begin
                pte_q <= mem_rsp_rdata;
            end
            if (st_q == S_CAS_WAIT && mem_rsp_valid && mem_rsp_ok) begin
                pte_q <= new_pte;
            end
        end
    end

    // Next state and outcome.
    always_comb begin
        st_d  = st_q;
        out_d = out_q;
        unique case (st_q)
            S_IDLE: begin
                if (req_valid) st_d = S_RD_CHK;
            end
            S_RD_CHK: begin
                if (!chk_rd_ok) begin
                    out_d = OUT_ACCESS;
                    st_d  = S_RESP;
                end else begin
                    st_d = S_RD_REQ;
                end
            end
            S_RD_REQ: begin
                st_d = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (mem_rsp_valid) st_d = S_EVAL;
            end
            S_EVAL: begin
                if (!need_upd) begin
                    out_d = OUT_DONE;
                    st_d  = S_RESP;
                end else if (!hw_ok) begin
                    out_d = OUT_PAGE;
                    st_d  = S_RESP;
                end else begin
                    st_d = S_WR_CHK;
                end
            end
            S_WR_CHK: begin
                if (!chk_wr_ok || !chk_cacheable) begin
                    out_d = OUT_ACCESS;
                    st_d  = S_RESP;
                end else begin
                    st_d = S_CAS_REQ;
                end
            end
            S_CAS_REQ: begin
                st_d = S_CAS_WAIT;
            end
            S_CAS_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_ok) begin
                        out_d = OUT_DONE;
                        st_d  = S_RESP;
                    end else begin
                        // Entry changed under us: walk the leaf again.
                        st_d = S_RD_CHK;
                    end
                end
            end
            S_RESP: begin
                st_d = S_IDLE;
            end
            default: begin
                st_d = S_IDLE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        cfg_rdata     = {sel_h, sel_m};
        req_ready     = (st_q == S_IDLE);
        mem_req_valid = (st_q == S_RD_REQ) || (st_q == S_CAS_REQ);
        mem_req_write = (st_q == S_CAS_REQ);
        mem_req_addr  = addr_q;
        mem_req_cmp   = pte_q;
        mem_req_wdata = (st_q == S_CAS_REQ) ? new_pte : pte_q;
        rsp_valid     = (st_q == S_RESP);
        rsp_code      = out_q;
        rsp_guest     = guest_q;
        rsp_acc       = acc_q;
        rsp_implicit  = impl_q;
        rsp_pte       = pte_q;
    end

endmodule

// File: rtl/pte_ad_unit_chk.sv
module pte_ad_unit_chk #(
    parameter int AW       = 32,
    parameter int PW       = 32,
    parameter int A_BIT    = 6,
    parameter int D_BIT    = 7,
    parameter bit HW_AD_EN = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_rdata,
    input logic          req_ready,
    input logic          chk_rd_ok,
    input logic          chk_wr_ok,
    input logic          chk_cacheable,
    input logic          mem_req_valid,
    input logic          mem_req_write,
    input logic [PW-1:0] mem_req_cmp,
    input logic [PW-1:0] mem_req_wdata,
    input logic          rsp_valid,
    input logic [1:0]    rsp_code
);

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r12_busy_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r12_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    a_r12_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'd3));

    a_r7_read_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> chk_rd_ok);

    a_r8_write_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (chk_wr_ok && chk_cacheable));

    a_r11_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |->
            (((mem_req_wdata & mem_req_cmp) == mem_req_cmp) && mem_req_wdata[A_BIT]));

    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

endmodule

bind pte_ad_unit pte_ad_unit_chk #(
    .AW       (AW),
    .PW       (PW),
    .A_BIT    (A_BIT),
    .D_BIT    (D_BIT),
    .HW_AD_EN (HW_AD_EN)
) u_chk (.*);

// File: tb/pte_ad_unit_tb.sv
`timescale 1ns/1ps
module pte_ad_unit_tb;

    localparam int AW = 32;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_wdata = 2'b00;
    logic [1:0]    cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_acc = '0;
    logic          req_implicit = 1'b0;
    logic          req_guest = 1'b0;
    logic          chk_rd_ok = 1'b1;
    logic          chk_wr_ok = 1'b1;
    logic          chk_cacheable = 1'b1;
    logic          mem_req_valid;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [PW-1:0] mem_req_cmp;
    logic [PW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic          mem_rsp_ok = 1'b0;
    logic [PW-1:0] mem_rsp_rdata = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic          rsp_guest;
    logic [1:0]    rsp_acc;
    logic          rsp_implicit;
    logic [PW-1:0] rsp_pte;

    // Read-only-zero build, only its selection register is exercised.
    logic [1:0]    nh_rdata;
    logic          nh_ready, nh_mv, nh_mw, nh_rv, nh_g, nh_i;
    logic [AW-1:0] nh_ma;
    logic [PW-1:0] nh_mc, nh_md, nh_pte;
    logic [1:0]    nh_code, nh_acc;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pte_ad_unit #(.AW(AW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_acc(req_acc), .req_implicit(req_implicit),
        .req_guest(req_guest), .chk_rd_ok(chk_rd_ok), .chk_wr_ok(chk_wr_ok),
        .chk_cacheable(chk_cacheable), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_cmp(mem_req_cmp), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ok(mem_rsp_ok),
        .mem_rsp_rdata(mem_rsp_rdata), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_guest(rsp_guest), .rsp_acc(rsp_acc),
        .rsp_implicit(rsp_implicit), .rsp_pte(rsp_pte)
    );

    pte_ad_unit #(.AW(AW), .PW(PW), .HW_AD_EN(1'b0)) u_dut_nohw (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(nh_rdata), .req_valid(1'b0), .req_ready(nh_ready),
        .req_addr('0), .req_acc(2'b00), .req_implicit(1'b0),
        .req_guest(1'b0), .chk_rd_ok(1'b1), .chk_wr_ok(1'b1),
        .chk_cacheable(1'b1), .mem_req_valid(nh_mv),
        .mem_req_write(nh_mw), .mem_req_addr(nh_ma),
        .mem_req_cmp(nh_mc), .mem_req_wdata(nh_md),
        .mem_rsp_valid(1'b0), .mem_rsp_ok(1'b0),
        .mem_rsp_rdata('0), .rsp_valid(nh_rv),
        .rsp_code(nh_code), .rsp_guest(nh_g), .rsp_acc(nh_acc),
        .rsp_implicit(nh_i), .rsp_pte(nh_pte)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural memory with one-cycle response and an optional interfering agent.
    logic [PW-1:0] mem [8];
    logic [PW-1:0] meddle = '0;
    int            nreads = 0;
    int            nwrites = 0;
    logic          pend = 1'b0;
    logic          p_wr;
    logic [2:0]    p_idx;
    logic [PW-1:0] p_cmp, p_wd;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            pend = 1'b0;
            mem_rsp_valid = 1'b1;
            if (p_wr) begin
                if (mem[p_idx] == p_cmp) begin
                    mem[p_idx] = p_wd;
                    mem_rsp_ok = 1'b1;
                    nwrites++;
                end else begin
                    mem_rsp_ok = 1'b0;
                end
                mem_rsp_rdata = mem[p_idx];
            end else begin
                mem_rsp_rdata = mem[p_idx];
                nreads++;
                mem[p_idx] = mem[p_idx] | meddle;
                meddle = '0;
            end
        end
        if (rst_n && mem_req_valid) begin
            pend  = 1'b1;
            p_wr  = mem_req_write;
            p_idx = mem_req_addr[4:2];
            p_cmp = mem_req_cmp;
            p_wd  = mem_req_wdata;
            if (mem_req_write)
                check("R11 write only sets bits", mem_req_wdata & mem_req_cmp, mem_req_cmp);
        end
    end

    logic cm = 1'b0;
    logic ch = 1'b0;

    task automatic set_cfg(input logic m, input logic h);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {h, m};
        @(negedge clk);
        cfg_we = 1'b0;
        cm = m;
        ch = h;
    endtask

    task automatic run_case(input string tag, input logic [PW-1:0] pte0, input logic [1:0] acc,
                            input logic guest, input logic impl, input logic rdok,
                            input logic wrok, input logic cach, input logic [PW-1:0] med);
        int code;
        int ew;
        int cyc;
        logic hw, need, st;
        logic [PW-1:0] r, cur, epte;
        // Reference outcome.
        st   = (acc == 2'd2);
        hw   = guest ? (cm && ch) : cm;
        code = -1;
        ew   = 0;
        epte = pte0;
        if (!rdok) begin
            code = 2;
            cur  = pte0;
        end else begin
            r   = pte0;
            cur = pte0 | med;
            for (int it = 0; it < 3 && code < 0; it++) begin
                need = !r[6] || (st && !r[7]);
                if (!need) begin
                    code = 0;
                    epte = r;
                end else if (!hw) begin
                    code = 1;
                end else if (!(cach && wrok)) begin
                    code = 2;
                end else if (cur == r) begin
                    cur  = r | 32'h40 | (st ? 32'h80 : 32'h0);
                    ew++;
                    code = 0;
                    epte = cur;
                end else begin
                    r = cur;
                end
            end
        end
        // Stimulus.
        mem[3] = pte0;
        meddle = med;
        nreads = 0;
        nwrites = 0;
        chk_rd_ok = rdok;
        chk_wr_ok = wrok;
        chk_cacheable = cach;
        @(negedge clk);
        check({tag, " ready before"}, req_ready, 1'b1);
        req_valid = 1'b1;
        req_addr = 32'h0000_100C;
        req_acc = acc;
        req_guest = guest;
        req_implicit = impl;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, " response seen"}, rsp_valid, 1'b1);
        check({tag, " outcome"}, rsp_code, code);
        check({tag, " acc echo"}, rsp_acc, acc);
        check({tag, " stage echo"}, rsp_guest, guest);
        check({tag, " implicit echo"}, rsp_implicit, impl);
        if (code == 0) check({tag, " pte"}, rsp_pte, epte);
        check({tag, " memory"}, mem[3], cur);
        check({tag, " writes"}, nwrites, ew);
        if (!rdok) check({tag, " no read"}, nreads, 0);
        @(negedge clk);
        check({tag, " R12 pulse ends"}, rsp_valid, 1'b0);
        check({tag, " R12 ready again"}, req_ready, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", req_ready, 1'b1);
        check("R1 rsp_valid", rsp_valid, 1'b0);
        check("R1 cfg", cfg_rdata, 2'b00);

        // Fault behaviour (selection 0).
        run_case("R2 load A set", 32'h0000_2041, 2'd1, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R2 store A D set", 32'h0000_20C1, 2'd2, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R3 load A clear", 32'h0000_2001, 2'd1, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R3 store D clear", 32'h0000_2041, 2'd2, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R3 guest fetch", 32'h0000_2001, 2'd0, 1'b1, 1'b0, 1, 1, 1, 0);
        run_case("R7 read denied", 32'h0000_2001, 2'd2, 1'b0, 1'b0, 0, 1, 1, 0);

        // WARL register.
        set_cfg(1'b1, 1'b1);
        @(negedge clk);
        check("R6 writable", cfg_rdata, 2'b11);
        check("R6 read-only-zero", nh_rdata, 2'b00);
        set_cfg(1'b0, 1'b1);
        run_case("R5 guest machine off", 32'h0000_2001, 2'd1, 1'b1, 1'b0, 1, 1, 1, 0);
        set_cfg(1'b1, 1'b0);
        check("R6 partial", cfg_rdata, 2'b01);
        run_case("R5 guest sel off", 32'h0000_2001, 2'd1, 1'b1, 1'b0, 1, 1, 1, 0);

        // Hardware update.
        run_case("R4 load sets A", 32'h0000_2001, 2'd1, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R4 fetch sets A", 32'h0000_2081, 2'd0, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R4 store sets AD", 32'h0000_2001, 2'd2, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R4 store D only", 32'h0000_2041, 2'd2, 1'b0, 1'b0, 1, 1, 1, 0);
        run_case("R10 implicit load", 32'h0000_2001, 2'd1, 1'b0, 1'b1, 1, 1, 1, 0);
        run_case("R8 write denied", 32'h0000_2001, 2'd2, 1'b0, 1'b0, 1, 0, 1, 0);
        run_case("R8 noncacheable", 32'h0000_2001, 2'd1, 1'b0, 1'b1, 1, 1, 0, 0);
        run_case("R9 race sets A", 32'h0000_2001, 2'd2, 1'b0, 1'b0, 1, 1, 1, 32'h40);
        run_case("R9 race sets soft", 32'h0000_2001, 2'd1, 1'b0, 1'b0, 1, 1, 1, 32'h100);
        run_case("R11 after update", 32'h0000_20C1, 2'd2, 1'b0, 1'b1, 1, 1, 1, 0);
        set_cfg(1'b1, 1'b1);
        run_case("R5 guest store update", 32'h0000_2001, 2'd2, 1'b1, 1'b0, 1, 1, 1, 0);
        run_case("R10 implicit guest", 32'h0000_2001, 2'd0, 1'b1, 1'b1, 1, 1, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule